// File: doc/BRIEF.md
# Timebase-to-Time-of-Day Sync Controller

This block controls the loading of a core's timebase from a chip-wide time-of-day (TOD) source. Software talks to it through one 64-bit control and status register over a plain read/write strobe port. The register carries a sequencing state, two command bits (modulo load and TOD transfer), a delayed sync flag and a firmware-misuse flag.

Progress is paced by software polling and not by the clock. Every register read is one step: it first counts down two small timers, and only when the state timer has drained does it attempt a state change. The TOD transfer is negotiated with the TOD network through a ready output and a sent acknowledge input. The sent input is held in a sticky latch until the sequencer uses it.

Register fields (other bits read as zero, write-only bits read as zero): state in bits [3:0] with codes 0 = idle (not set), 1 = waiting for sync, 2 = fetching TOD, 3 = timebase running, 4 = error; bit 8 = modulo-load command; bit 9 = TOD-transfer command; bit 10 = sync-seen flag; bit 11 = firmware-error flag (write 1 to clear); bit 12 = abort (write-only).

Top module: `tbsync_ctrl`

## Requirements
- R1: After reset the read data is zero, `tod_ready` is low, the state is idle (code 0) and both timers are zero, so the first read after reset already shows the sync-seen flag (bit 10).
- R2: A read (`rd_en` high, `wr_en` low) updates `rd_data` at the next clock edge with the register value that includes every change made by that same read, and `rd_data` holds between reads.
- R3: Every write clears the sync-seen flag (bit 10) and loads the sync-pulse timer with `PULSE_WAIT`; each read decrements that timer while it is nonzero and sets the flag once it is zero, so with the default of 1 the flag shows from the second read after a write.
- R4: A read attempts a state change only when the state timer is zero; while it is nonzero, the read only decrements it.
- R5: Writing the TOD-transfer bit (bit 9) while idle moves to waiting-for-sync (code 1), raises `tod_ready` and loads the state timer with `STATE_WAIT`.
- R6: A state-change read in waiting-for-sync with the transfer bit set moves to fetching-TOD (code 2) and reloads the state timer with `STATE_WAIT`.
- R7: `tod_sent` is latched until used; a state-change read in fetching-TOD with the latch set moves to timebase-running (code 3), clears the transfer bit, lowers `tod_ready` and clears the latch; with the latch clear the state stays in fetching-TOD.
- R8: Writing the transfer bit in any state other than idle moves to error (code 4), sets the firmware-error flag (bit 11) and lowers `tod_ready`.
- R9: A write after which modulo-load (bit 8) and transfer (bit 9) would both be set moves to error, sets the firmware-error flag, lowers `tod_ready` and leaves both command bits as they were.
- R10: Writing the modulo-load bit loads the state timer with `STATE_WAIT`; the next state-change read clears the modulo-load bit and leaves the state code unchanged.
- R11: A write with the abort bit (bit 12) clears both command bits, the firmware-error flag, `tod_ready` and the sent latch and returns the state to idle.
- R12: Writing 1 to bit 11 clears the firmware-error flag without changing the state or the command bits.
- R13: When `rd_en` and `wr_en` are high in the same cycle, the write is performed and the read is ignored: `rd_data` keeps its value and no timer is decremented.
- R14: A state-change read with the transfer bit set in a state other than waiting-for-sync or fetching-TOD moves to error and sets the firmware-error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Register read strobe, one step per cycle high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write value |
| rd_data | output | REG_W | Register value captured by the last read |
| tod_sent | input | 1 | TOD network reports that the TOD value was delivered |
| tod_ready | output | 1 | Timebase is ready to take the TOD value |

## Verification
The bench builds the block with the default widths and waits: a 64-bit register, a state timer of 3 and a sync-pulse timer of 1. These values make the exact read counts observable: the flag appears on the second read after a write, and a state change lands on the fourth read after a timer load. This makes it possible to check both the drain-then-step rule and a fetching-TOD step that waits for a late acknowledge. The error paths are reached from the waiting, running and error states, with the flag cleared and raised again by polling.

// File: rtl/tbsync_pkg.sv
// Package: shared state encoding and register field positions for the
// timebase sync controller. Positions are fixed because software decodes them.
package tbsync_pkg;

    localparam int STATE_LSB = 0;
    localparam int STATE_W   = 4;
    localparam int BIT_LOAD  = 8;   // modulo-load command
    localparam int BIT_MOVE  = 9;   // TOD-transfer command
    localparam int BIT_SYNC  = 10;  // sync-seen flag
    localparam int BIT_FERR  = 11;  // firmware-error flag, write 1 to clear
    localparam int BIT_ABORT = 12;  // write-only abort

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 4'd0,
        ST_SYNCWAIT = 4'd1,
        ST_GETTOD   = 4'd2,
        ST_RUNNING  = 4'd3,
        ST_ERROR    = 4'd4
    } tb_state_e;

endpackage

// File: rtl/tbsync_countdown.sv
// Module: tbsync_countdown
// Down counter paced by read steps. A load sets it to LOAD_VAL; a decrement
// request lowers it by one and stops at zero. Assumes load and dec are not
// both needed in one cycle (load wins if they are).
module tbsync_countdown #(
    parameter int LOAD_VAL = 3,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] count_q;

    // Count register: reset to zero, load wins, decrement saturates at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= CNT_W'(LOAD_VAL);
        end else if (dec && (count_q != '0)) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Zero flag used by the sequencer to decide between countdown and step.
    always_comb zero = (count_q == '0);

    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(LOAD_VAL));

    assert_dec_lowers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/tbsync_fsm.sv
// Module: tbsync_fsm
// Sequencer and register state. Decodes writes (commands, abort, flag clear,
// misuse detection) and read steps (timer countdown, state change), and
// presents the register value the current cycle will leave behind.
// Assumes timer zero flags come from registered counters.
module tbsync_fsm
    import tbsync_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tod_sent,
    input  logic             pt_zero,
    input  logic             st_zero,
    output logic             pt_load,
    output logic             pt_dec,
    output logic             st_load,
    output logic             st_dec,
    output logic             tod_ready,
    output logic [REG_W-1:0] reg_nxt
);

    tb_state_e state_q, state_d;
    logic      load_q, load_d;
    logic      move_q, move_d;
    logic      sync_q, sync_d;
    logic      ferr_q, ferr_d;
    logic      rdy_q,  rdy_d;
    logic      sent_q, sent_d;
    logic      rd_step;
    logic      w_load, w_move, w_clr, w_abort, w_clash;

    // Write field decode.
    always_comb begin
        w_load  = wr_data[BIT_LOAD];
        w_move  = wr_data[BIT_MOVE];
        w_clr   = wr_data[BIT_FERR];
        w_abort = wr_data[BIT_ABORT];
        w_clash = (load_q | w_load) & (move_q | w_move);
        rd_step = rd_en & ~wr_en;
    end

    // Next-state logic for writes and read steps.
    always_comb begin
        state_d = state_q;
        load_d  = load_q;
        move_d  = move_q;
        sync_d  = sync_q;
        ferr_d  = ferr_q;
        rdy_d   = rdy_q;
        sent_d  = sent_q | tod_sent;
        pt_load = 1'b0;
        st_load = 1'b0;
        if (wr_en) begin
            sync_d  = 1'b0;
            pt_load = 1'b1;
            if (w_abort) begin
                load_d  = 1'b0;
                move_d  = 1'b0;
                ferr_d  = 1'b0;
                rdy_d   = 1'b0;
                sent_d  = 1'b0;
                state_d = ST_IDLE;
            end else if (w_clash) begin
                state_d = ST_ERROR;
                ferr_d  = 1'b1;
                rdy_d   = 1'b0;
            end else begin
                load_d = load_q | w_load;
                move_d = move_q | w_move;
                if (w_clr) ferr_d = 1'b0;
                if (w_load) begin
                    st_load = 1'b1;
                end else if (w_move) begin
                    if (state_q == ST_IDLE) begin
                        state_d = ST_SYNCWAIT;
                        rdy_d   = 1'b1;
                        st_load = 1'b1;
                    end else begin
                        state_d = ST_ERROR;
                        ferr_d  = 1'b1;
                        rdy_d   = 1'b0;
                    end
                end
            end
        end else if (rd_step) begin
            if (pt_zero) sync_d = 1'b1;
            if (st_zero) begin
                if (load_q) begin
                    load_d = 1'b0;
                end else if (move_q) begin
                    if (state_q == ST_SYNCWAIT) begin
                        state_d = ST_GETTOD;
                        st_load = 1'b1;
                    end else if (state_q == ST_GETTOD) begin
                        if (sent_q) begin
                            state_d = ST_RUNNING;
                            move_d  = 1'b0;
                            rdy_d   = 1'b0;
                            sent_d  = 1'b0;
                        end
                    end else begin
                        state_d = ST_ERROR;
                        ferr_d  = 1'b1;
                        rdy_d   = 1'b0;
                    end
                end
            end
        end
        pt_dec = rd_step & ~pt_zero;
        st_dec = rd_step & ~st_zero;
    end

    // State and flag registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            load_q  <= 1'b0;
            move_q  <= 1'b0;
            sync_q  <= 1'b0;
            ferr_q  <= 1'b0;
            rdy_q   <= 1'b0;
            sent_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            load_q  <= load_d;
            move_q  <= move_d;
            sync_q  <= sync_d;
            ferr_q  <= ferr_d;
            rdy_q   <= rdy_d;
            sent_q  <= sent_d;
        end
    end

    // Register image after this cycle, captured by the read port.
    always_comb begin
        reg_nxt = '0;
        reg_nxt[STATE_LSB +: STATE_W] = state_d;
        reg_nxt[BIT_LOAD] = load_d;
        reg_nxt[BIT_MOVE] = move_d;
        reg_nxt[BIT_SYNC] = sync_d;
        reg_nxt[BIT_FERR] = ferr_d;
        tod_ready = rdy_q;
    end

    assert_ready_states_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |-> (state_q == ST_SYNCWAIT || state_q == ST_GETTOD));

    assert_ferr_in_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_q |-> (state_q == ST_ERROR));

    assert_write_clears_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !sync_q);

    assert_sync_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q) |-> $past(rd_en && !wr_en));

    assert_clash_errors_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[BIT_ABORT] && (load_q || wr_data[BIT_LOAD])
               && (move_q || wr_data[BIT_MOVE]))
        |=> (state_q == ST_ERROR && ferr_q && !rdy_q));

    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_ABORT]) |=> (state_q == ST_IDLE && !rdy_q && !ferr_q));

endmodule

// File: rtl/tbsync_ctrl.sv
// Module: tbsync_ctrl (top)
// Timebase-to-TOD sync controller: a polled control register whose sequencer
// steps once per read, paced by a state timer and a sync-pulse timer.
// Assumes REG_W >= 13 so every field fits.
module tbsync_ctrl #(
    parameter int REG_W      = 64,
    parameter int STATE_WAIT = 3,
    parameter int PULSE_WAIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             tod_sent,
    output logic             tod_ready
);

    localparam int ST_CNT_W = (STATE_WAIT < 2) ? 1 : $clog2(STATE_WAIT + 1);
    localparam int PT_CNT_W = (PULSE_WAIT < 2) ? 1 : $clog2(PULSE_WAIT + 1);

    logic             pt_zero, st_zero;
    logic             pt_load, pt_dec, st_load, st_dec;
    logic [REG_W-1:0] reg_nxt;

    tbsync_fsm #(.REG_W(REG_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tod_sent  (tod_sent),
        .pt_zero   (pt_zero),
        .st_zero   (st_zero),
        .pt_load   (pt_load),
        .pt_dec    (pt_dec),
        .st_load   (st_load),
        .st_dec    (st_dec),
        .tod_ready (tod_ready),
        .reg_nxt   (reg_nxt)
    );

    tbsync_countdown #(.LOAD_VAL(STATE_WAIT), .CNT_W(ST_CNT_W)) u_state_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (st_load),
        .dec   (st_dec),
        .zero  (st_zero)
    );

    tbsync_countdown #(.LOAD_VAL(PULSE_WAIT), .CNT_W(PT_CNT_W)) u_pulse_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pt_load),
        .dec   (pt_dec),
        .zero  (pt_zero)
    );

    // Read port: capture the post-step register image on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en && !wr_en) begin
            rd_data <= reg_nxt;
        end
    end

    assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> $stable(rd_data));

endmodule

// File: tb/sim_tbsync_ctrl.sv
module sim_tbsync_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W      = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_en = 1'b0;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_data;
    logic             tod_sent = 1'b0;
    logic             tod_ready;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    tbsync_ctrl #(.REG_W(REG_W), .STATE_WAIT(3), .PULSE_WAIT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .tod_sent(tod_sent), .tod_ready(tod_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [63:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_read(input string req, input logic [63:0] exp);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check(req, rd_data, exp);
    endtask

    task automatic pulse_sent();
        @(negedge clk); tod_sent = 1'b1;
        @(negedge clk); tod_sent = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, 64'h0);
        check("R1 tod_ready after reset", {63'b0, tod_ready}, 64'h0);
        do_read("R1 first read shows sync flag", 64'h400);
    endtask

    task automatic t_sync_pulse();
        do_write(64'h0);
        do_read("R3 first read after write", 64'h000);
        do_read("R3 second read after write", 64'h400);
        do_read("R2 read holds value", 64'h400);
    endtask

    task automatic t_transfer();
        do_write(64'h200);
        check("R5 ready raised", {63'b0, tod_ready}, 64'h1);
        do_read("R5 sync-wait state", 64'h201);
        do_read("R4 countdown read 2", 64'h601);
        do_read("R4 countdown read 3", 64'h601);
        do_read("R6 step to get-tod", 64'h602);
        do_read("R4 get-tod countdown 1", 64'h602);
        do_read("R4 get-tod countdown 2", 64'h602);
        do_read("R4 get-tod countdown 3", 64'h602);
        do_read("R7 waits without sent", 64'h602);
        check("R7 ready held while waiting", {63'b0, tod_ready}, 64'h1);
        pulse_sent();
        check("R7 latch alone changes nothing", rd_data, 64'h602);
        do_read("R7 running after sent", 64'h403);
        check("R7 ready dropped", {63'b0, tod_ready}, 64'h0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; wr_data = '0;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        check("R13 rd_data unchanged", rd_data, 64'h403);
        do_read("R13 pulse timer not decremented", 64'h003);
    endtask

    task automatic t_bad_transfer();
        do_write(64'h200);
        check("R8 ready low after misuse", {63'b0, tod_ready}, 64'h0);
        do_read("R8 error with flag", 64'hA04);
        do_write(64'h800);
        do_read("R14 step re-raises error flag", 64'hA04);
        do_read("R14 flag stays", 64'hE04);
    endtask

    task automatic t_abort();
        do_write(64'h1000);
        check("R11 ready low after abort", {63'b0, tod_ready}, 64'h0);
        do_read("R11 cleared to idle", 64'h000);
    endtask

    task automatic t_modulo();
        do_write(64'h100);
        do_read("R10 modulo countdown 1", 64'h100);
        do_read("R10 modulo countdown 2", 64'h500);
        do_read("R10 modulo countdown 3", 64'h500);
        do_read("R10 modulo bit cleared", 64'h400);
    endtask

    task automatic t_clash();
        do_write(64'h200);
        check("R9 ready raised before clash", {63'b0, tod_ready}, 64'h1);
        do_write(64'h100);
        check("R9 ready dropped by clash", {63'b0, tod_ready}, 64'h0);
        do_read("R9 clash error keeps commands", 64'hA04);
        do_write(64'h1000);
        do_write(64'h100);
        do_read("R10 load sets timer", 64'h100);
        do_write(64'h200);
        do_read("R9 clash from modulo", 64'h904);
        do_write(64'h800);
        do_read("R12 flag cleared by write-1", 64'h104);
        do_read("R10 step clears modulo in error", 64'h404);
    endtask

    initial begin
        t_reset();
        t_sync_pulse();
        t_transfer();
        t_same_cycle();
        t_bad_transfer();
        t_abort();
        t_modulo();
        t_clash();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule